// File: doc/BRIEF.md
# Segment Mapping and Page Translation Cache

This block turns a 32-bit effective address into a real address for a paged memory unit. The top four address bits pick one of sixteen segment registers. A segment register supplies a 24-bit virtual segment identifier, one protection key for supervisor state and one for problem state, and a no-execute flag. The virtual segment identifier and the 16-bit page index then look up a 64-slot direct-mapped translation cache. A separate cache serves instruction fetches and another serves data accesses. A hit returns a 20-bit real page number, two page-protection bits and a changed flag.

A requester pulses a request and receives one registered response with a fault code and a real address. On a cache miss the block asks an external table walker for the mapping and waits until it answers. A found mapping fills the cache and the lookup is retried. A missing mapping is reported as a page fault. The first permitted write to a page whose changed flag is clear produces a one-cycle update request, and the flag is then set locally. Software maintenance can invalidate one slot or every slot, in both caches at once.

Top module: `segTlbXlate`

## Requirements
- R1: After reset, reqReady is 1 and rspValid, walkReq, chgReq and cfgErr are 0. Every cache slot holds the all-ones tag, so the first access to any page requests a walk.
- R2: The segment is selected by effective address bits [31:28]. In a segment word, bit 30 is the supervisor key, bit 29 the problem-state key, bit 28 no-execute and bits [23:0] the virtual segment identifier. The identifier is shown on walkVsid, and the held request address is shown on walkAddr.
- R3: A segment write with bit 31 set leaves the addressed segment unchanged and raises cfgErr for exactly the one cycle after the write.
- R4: A fetch (reqKind 2) through a no-execute segment responds with rspFault 1 (protection) and issues no walk.
- R5: On a miss, walkReq stays high until walkDone. When walkDone comes with walkHit 0, the response has rspFault 2 (page fault).
- R6: A cache hit responds two clock edges after the request is accepted. With no fault (rspFault 0), rspRealAddr equals the real page number followed by effective address bits [11:0].
- R7: A hit needs both a stored identifier equal to the segment's identifier and a stored page index equal to address bits [27:12]. The slot is chosen by address bits [17:12], and a walker fill replaces that slot.
- R8: The key is the problem-state key when reqProb is 1 and the supervisor key otherwise. Key 0 allows every access except a write (reqKind 1) to protection value 3. Key 1 denies every access to protection value 0, allows reads, writes and fetches to protection value 2, and allows only reads and fetches to values 1 and 3. A denial gives rspFault 1.
- R9: A permitted write that hits a slot whose changed flag is clear pulses chgReq together with the response. chgPteAddr carries the stored second-word address of the table entry, and memory is to set bit 7 (C) of that word. Later writes to the page, writes to a page filled with walkChanged 1, and denied writes give no pulse.
- R10: invOne forces the all-ones tag into slot invAddr[17:12] of both caches and leaves other slots intact.
- R11: invAll forces the all-ones tag into every slot of both caches.
- R12: A fetch looks up and fills only the instruction cache. Reads (reqKind 0) and writes look up and fill only the data cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register number |
| segWrData | input | 32 | Segment register value |
| cfgErr | output | 1 | Unsupported segment value rejected |
| reqValid | input | 1 | Translation request pulse |
| reqReady | output | 1 | Block idle, request accepted |
| reqAddr | input | 32 | Effective address |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch |
| reqProb | input | 1 | Problem state |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 2 | 0 none, 1 protection, 2 page fault |
| rspRealAddr | output | 32 | Translated real address |
| walkReq | output | 1 | Table walk request |
| walkVsid | output | 24 | Segment identifier for the walk |
| walkAddr | output | 32 | Effective address for the walk |
| walkDone | input | 1 | Walker answer strobe |
| walkHit | input | 1 | Walker found a mapping |
| walkRpn | input | 20 | Real page number from walker |
| walkPp | input | 2 | Protection bits from walker |
| walkChanged | input | 1 | Changed flag from walker |
| walkPteAddr | input | 32 | Address of the entry's second word |
| chgReq | output | 1 | Changed-bit update pulse |
| chgPteAddr | output | 32 | Word to update |
| invOne | input | 1 | Invalidate one slot |
| invAll | input | 1 | Invalidate all slots |
| invAddr | input | 32 | Address selecting the slot to invalidate |

## Verification
A corrupted tag shows at the ports on the next access to that slot. A false hit produces a response two edges after the request with no walk in between, and a false miss raises walkReq instead. A wrong changed flag or protection field shows on that same response as a missing or extra chgReq pulse, or as the wrong rspFault code. A segment corrupted by a rejected write shows in the identifier on walkVsid at the next miss through that segment. Evictions, invalidations and key selection are each driven so that the slot or flag they touch is read back in the following access.

// File: rtl/segtlb_pkg.sv
package segtlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_PROT = 2'd1;
  localparam logic [1:0] FLT_PAGE = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic fill;
    logic fillInstr;
    logic setChg;
  } ctlStrobe_t;

  // lookup summary from datapath to control
  typedef struct packed {
    logic        noExec;
    logic        hit;
    logic        allowed;
    logic        changed;
    logic        isWrite;
    logic        isFetch;
    logic [31:0] realAddr;
    logic [31:0] pteAddr;
  } lookRes_t;

  function automatic logic accessOk(input logic key, input logic [1:0] pp,
                                    input accKind_t kind);
    logic ok;
    if (!key) begin
      ok = !(kind == ACC_WRITE && pp == 2'b11);
    end else begin
      case (pp)
        2'b00:   ok = 1'b0;
        2'b10:   ok = 1'b1;
        default: ok = (kind != ACC_WRITE);
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/segtlb_datapath.sv
module segtlb_datapath
  import segtlb_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int IDX_BITS = 6,
  parameter int VSID_W   = 24,
  parameter int RPN_W    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                segWrEn,
  input  logic [SEG_BITS-1:0] segWrIdx,
  input  logic [31:0]         segWrData,
  output logic                cfgErr,
  input  logic [31:0]         reqAddr,
  input  logic [1:0]          reqKind,
  input  logic                reqProb,
  input  ctlStrobe_t          strobe,
  input  logic                invOne,
  input  logic                invAll,
  input  logic [31:0]         invAddr,
  input  logic [RPN_W-1:0]    walkRpn,
  input  logic [1:0]          walkPp,
  input  logic                walkChanged,
  input  logic [31:0]         walkPteAddr,
  output lookRes_t            look,
  output logic [VSID_W-1:0]   curVsid,
  output logic [31:0]         curAddr
);

  localparam int SEG_N   = 1 << SEG_BITS;
  localparam int TLB_N   = 1 << IDX_BITS;
  localparam int OFF_W   = 32 - RPN_W;
  localparam int PAGE_W  = 32 - SEG_BITS - OFF_W;
  localparam int TPAGE_W = PAGE_W - IDX_BITS;

  // segment register file
  logic              segKs  [SEG_N];
  logic              segKp  [SEG_N];
  logic              segNx  [SEG_N];
  logic [VSID_W-1:0] segVsid[SEG_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_N; i++) begin
        segKs[i]   <= 1'b0;
        segKp[i]   <= 1'b0;
        segNx[i]   <= 1'b0;
        segVsid[i] <= '0;
      end
      cfgErr <= 1'b0;
    end else begin
      cfgErr <= segWrEn && segWrData[31];
      if (segWrEn && !segWrData[31]) begin
        segKs[segWrIdx]   <= segWrData[30];
        segKp[segWrIdx]   <= segWrData[29];
        segNx[segWrIdx]   <= segWrData[28];
        segVsid[segWrIdx] <= segWrData[VSID_W-1:0];
      end
    end
  end

  // held request
  logic [31:0] qAddr;
  accKind_t    qKind;
  logic        qProb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qAddr <= '0;
      qKind <= ACC_READ;
      qProb <= 1'b0;
    end else if (strobe.latch) begin
      qAddr <= reqAddr;
      qKind <= accKind_t'(reqKind);
      qProb <= reqProb;
    end
  end

  logic [SEG_BITS-1:0] segIdx;
  logic [IDX_BITS-1:0] slot;
  logic [IDX_BITS-1:0] invSlot;
  logic [TPAGE_W-1:0]  tagPage;
  logic                selInstr;

  assign segIdx   = qAddr[31 -: SEG_BITS];
  assign slot     = qAddr[OFF_W +: IDX_BITS];
  assign invSlot  = invAddr[OFF_W +: IDX_BITS];
  assign tagPage  = qAddr[OFF_W+IDX_BITS +: TPAGE_W];
  assign curVsid  = segVsid[segIdx];
  assign curAddr  = qAddr;
  assign selInstr = (qKind == ACC_FETCH);

  // per-side lookup results: index 0 data, index 1 instruction
  logic             sideHit [2];
  logic [RPN_W-1:0] sideRpn [2];
  logic [1:0]       sidePp  [2];
  logic             sideChg [2];
  logic [31:0]      sidePte [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [VSID_W-1:0]  tVsid [TLB_N];
    logic [TPAGE_W-1:0] tPage [TLB_N];
    logic [RPN_W-1:0]   tRpn  [TLB_N];
    logic [1:0]         tPp   [TLB_N];
    logic               tChg  [TLB_N];
    logic [31:0]        tPte  [TLB_N];
    logic               fillHere;

    assign fillHere = strobe.fill && (strobe.fillInstr == (s == 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < TLB_N; i++) begin
          tVsid[i] <= '1;
          tPage[i] <= '0;
          tRpn[i]  <= '0;
          tPp[i]   <= '0;
          tChg[i]  <= 1'b0;
          tPte[i]  <= '0;
        end
      end else begin
        if (fillHere) begin
          tVsid[slot] <= curVsid;
          tPage[slot] <= tagPage;
          tRpn[slot]  <= walkRpn;
          tPp[slot]   <= walkPp;
          tChg[slot]  <= walkChanged;
          tPte[slot]  <= walkPteAddr;
        end
        if (strobe.setChg && s == 0) begin
          tChg[slot] <= 1'b1;
        end
        // invalidation wins over a fill in the same cycle
        if (invAll) begin
          for (int i = 0; i < TLB_N; i++) begin
            tVsid[i] <= '1;
          end
        end else if (invOne) begin
          tVsid[invSlot] <= '1;
        end
      end
    end

    assign sideHit[s] = (tVsid[slot] == curVsid) && (tPage[slot] == tagPage);
    assign sideRpn[s] = tRpn[slot];
    assign sidePp[s]  = tPp[slot];
    assign sideChg[s] = tChg[slot];
    assign sidePte[s] = tPte[slot];
  end

  logic segKey;
  assign segKey = qProb ? segKp[segIdx] : segKs[segIdx];

  always_comb begin
    look          = '0;
    look.noExec   = segNx[segIdx] && selInstr;
    look.hit      = sideHit[selInstr];
    look.allowed  = accessOk(segKey, sidePp[selInstr], qKind);
    look.changed  = sideChg[selInstr];
    look.isWrite  = (qKind == ACC_WRITE);
    look.isFetch  = selInstr;
    look.realAddr = {sideRpn[selInstr], qAddr[OFF_W-1:0]};
    look.pteAddr  = sidePte[selInstr];
  end

  // a rejected segment value leaves the register as it was
  assert_tbit_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segWrData[31]) |=>
      (segVsid[$past(segWrIdx)] == $past(segVsid[segWrIdx]) &&
       segNx[$past(segWrIdx)] == $past(segNx[segWrIdx])));

  // after invalidate-all nothing hits unless the identifier is all ones
  assert_inv_all_miss_R11: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (curVsid == '1) || (!sideHit[0] && !sideHit[1]));

endmodule

// File: rtl/segtlb_control.sv
module segtlb_control
  import segtlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  lookRes_t   look,
  input  logic       walkDone,
  input  logic       walkHit,
  output ctlStrobe_t strobe,
  output logic       walkReq,
  output logic       rspValid,
  output logic [1:0] rspFault,
  output logic [31:0] rspRealAddr,
  output logic       chgReq,
  output logic [31:0] chgPteAddr
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WALK} state_t;

  state_t      state, stateNext;
  logic        doRsp;
  logic [1:0]  fltNext;
  logic        doChg;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doRsp     = 1'b0;
    fltNext   = FLT_NONE;
    doChg     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latch = 1'b1;
          stateNext    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        stateNext = ST_IDLE;
        if (look.noExec) begin
          doRsp   = 1'b1;
          fltNext = FLT_PROT;
        end else if (!look.hit) begin
          stateNext = ST_WALK;
        end else if (!look.allowed) begin
          doRsp   = 1'b1;
          fltNext = FLT_PROT;
        end else begin
          doRsp = 1'b1;
          if (look.isWrite && !look.changed) begin
            doChg         = 1'b1;
            strobe.setChg = 1'b1;
          end
        end
      end
      ST_WALK: begin
        if (walkDone) begin
          if (walkHit) begin
            strobe.fill      = 1'b1;
            strobe.fillInstr = look.isFetch;
            stateNext        = ST_LOOK;
          end else begin
            doRsp     = 1'b1;
            fltNext   = FLT_PAGE;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      rspValid    <= 1'b0;
      rspFault    <= FLT_NONE;
      rspRealAddr <= '0;
      chgReq      <= 1'b0;
      chgPteAddr  <= '0;
    end else begin
      state    <= stateNext;
      rspValid <= doRsp;
      chgReq   <= doChg;
      if (doRsp) begin
        rspFault    <= fltNext;
        rspRealAddr <= look.realAddr;
      end
      if (doChg) begin
        chgPteAddr <= look.pteAddr;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign walkReq  = (state == ST_WALK);

  // an update request only comes with a fault-free response
  assert_chg_with_ok_R9: assert property (@(posedge clk) disable iff (!rstN)
    chgReq |-> (rspValid && rspFault == FLT_NONE));

  // the walk request is held until the walker answers
  assert_walk_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkDone) |=> walkReq);

  // a no-execute fetch never reaches the walker
  assert_noexec_no_walk_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOK && look.noExec) |=> (!walkReq && rspValid && rspFault == FLT_PROT));

  // a response always lands with the block idle again
  assert_rsp_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

endmodule

// File: rtl/segTlbXlate.sv
module segTlbXlate
  import segtlb_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int IDX_BITS = 6,
  parameter int VSID_W   = 24,
  parameter int RPN_W    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                segWrEn,
  input  logic [SEG_BITS-1:0] segWrIdx,
  input  logic [31:0]         segWrData,
  output logic                cfgErr,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [31:0]         reqAddr,
  input  logic [1:0]          reqKind,
  input  logic                reqProb,
  output logic                rspValid,
  output logic [1:0]          rspFault,
  output logic [31:0]         rspRealAddr,
  output logic                walkReq,
  output logic [VSID_W-1:0]   walkVsid,
  output logic [31:0]         walkAddr,
  input  logic                walkDone,
  input  logic                walkHit,
  input  logic [RPN_W-1:0]    walkRpn,
  input  logic [1:0]          walkPp,
  input  logic                walkChanged,
  input  logic [31:0]         walkPteAddr,
  output logic                chgReq,
  output logic [31:0]         chgPteAddr,
  input  logic                invOne,
  input  logic                invAll,
  input  logic [31:0]         invAddr
);

  ctlStrobe_t strobe;
  lookRes_t   look;

  segtlb_datapath #(
    .SEG_BITS(SEG_BITS),
    .IDX_BITS(IDX_BITS),
    .VSID_W  (VSID_W),
    .RPN_W   (RPN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .segWrEn    (segWrEn),
    .segWrIdx   (segWrIdx),
    .segWrData  (segWrData),
    .cfgErr     (cfgErr),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .reqProb    (reqProb),
    .strobe     (strobe),
    .invOne     (invOne),
    .invAll     (invAll),
    .invAddr    (invAddr),
    .walkRpn    (walkRpn),
    .walkPp     (walkPp),
    .walkChanged(walkChanged),
    .walkPteAddr(walkPteAddr),
    .look       (look),
    .curVsid    (walkVsid),
    .curAddr    (walkAddr)
  );

  segtlb_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .look       (look),
    .walkDone   (walkDone),
    .walkHit    (walkHit),
    .strobe     (strobe),
    .walkReq    (walkReq),
    .rspValid   (rspValid),
    .rspFault   (rspFault),
    .rspRealAddr(rspRealAddr),
    .chgReq     (chgReq),
    .chgPteAddr (chgPteAddr)
  );

endmodule

// File: tb/segTlbXlate_bench.sv
module segTlbXlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        cfgErr;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqProb = 1'b0;
  logic        rspValid;
  logic [1:0]  rspFault;
  logic [31:0] rspRealAddr;
  logic        walkReq;
  logic [23:0] walkVsid;
  logic [31:0] walkAddr;
  logic        walkDone = 1'b0;
  logic        walkHit = 1'b0;
  logic [19:0] walkRpn = '0;
  logic [1:0]  walkPp = '0;
  logic        walkChanged = 1'b0;
  logic [31:0] walkPteAddr = '0;
  logic        chgReq;
  logic [31:0] chgPteAddr;
  logic        invOne = 1'b0;
  logic        invAll = 1'b0;
  logic [31:0] invAddr = '0;

  always #4 clk = ~clk;

  segTlbXlate u_segTlbXlate (.*);

  int nChecks = 0;
  int nFails  = 0;
  logic [23:0] segModel [16];

  task automatic check(input logic ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pteFor(input logic [19:0] rpn);
    return {9'h0, rpn, 3'b100};
  endfunction

  task automatic segWrite(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
    if (!val[31]) segModel[idx] = val[23:0];
  endtask

  // walk: 0 none expected, 1 answer with a fill, 2 answer with a miss
  task automatic access(input logic [1:0] kind, input logic prob, input logic [31:0] addr,
                        input logic [1:0] walk, input logic [19:0] rpn, input logic [1:0] pp,
                        input logic chg, input logic [1:0] expFlt, input logic [31:0] expRa,
                        input logic expChg, input int req);
    int lat = 0;
    logic done = 1'b0;
    logic sawWalk = 1'b0;
    logic [1:0] gotFlt = '0;
    logic [31:0] gotRa = '0;
    logic gotChg = 1'b0;
    logic [31:0] gotPte = '0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqKind = kind; reqProb = prob;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
      reqValid = 1'b0;
      walkDone = 1'b0;
      if (rspValid) begin
        done = 1'b1;
        gotFlt = rspFault; gotRa = rspRealAddr; gotChg = chgReq; gotPte = chgPteAddr;
      end else if (walkReq && !sawWalk) begin
        sawWalk = 1'b1;
        // R2: segment identifier and address handed to the walker
        check(walkVsid == segModel[addr[31:28]], 2, "walk vsid",
              {8'h0, walkVsid}, {8'h0, segModel[addr[31:28]]});
        check(walkAddr == addr, 2, "walk addr", walkAddr, addr);
        walkDone = 1'b1;
        walkHit = (walk == 2'd1);
        walkRpn = rpn; walkPp = pp; walkChanged = chg; walkPteAddr = pteFor(rpn);
      end
    end
    walkDone = 1'b0;
    check(done, req, "response seen", {31'h0, done}, 32'h1);
    check(sawWalk == (walk != 2'd0), req, "walk issued", {31'h0, sawWalk},
          {31'h0, walk != 2'd0});
    check(gotFlt == expFlt, req, "fault code", {30'h0, gotFlt}, {30'h0, expFlt});
    if (expFlt == 2'd0)
      check(gotRa == expRa, req, "real address", gotRa, expRa);
    check(gotChg == expChg, req, "change request", {31'h0, gotChg}, {31'h0, expChg});
    if (expChg)
      check(gotPte == pteFor(expRa[31:12]), req, "change address", gotPte, pteFor(expRa[31:12]));
    if (walk == 2'd0 && done)
      check(lat == 2, 6, "hit latency", lat, 32'd2);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic        prob;
    logic [31:0] addr;
    logic [1:0]  walk;
    logic [19:0] rpn;
    logic [1:0]  pp;
    logic        chg;
    logic [1:0]  flt;
    logic [31:0] ra;
    logic        chgReq;
    logic [7:0]  req;
  } vec_t;

  // segments: 0 = Ks0 Kp1 vsid 111, 1 = Ks1 Kp1 noexec vsid 222, 2 = Ks0 Kp0 vsid 333
  localparam vec_t VECS [18] = '{
    '{2'd0, 1'b0, 32'h0000_5123, 2'd1, 20'hABCDE, 2'b11, 1'b0, 2'd0, 32'hABCD_E123, 1'b0, 8'd5},  // R5 miss then fill
    '{2'd0, 1'b0, 32'h0000_5FFC, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'hABCD_EFFC, 1'b0, 8'd6},  // R6 hit
    '{2'd1, 1'b0, 32'h0000_5000, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8},  // R8 key0 pp3 write
    '{2'd0, 1'b1, 32'h0000_5010, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'hABCD_E010, 1'b0, 8'd8},  // R8 key1 pp3 read
    '{2'd1, 1'b1, 32'h0000_5020, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8},  // R8 key1 pp3 write
    '{2'd1, 1'b0, 32'h0000_6040, 2'd1, 20'h12345, 2'b10, 1'b0, 2'd0, 32'h1234_5040, 1'b1, 8'd9},  // R9 first write
    '{2'd1, 1'b0, 32'h0000_6044, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'h1234_5044, 1'b0, 8'd9},  // R9 no repeat
    '{2'd1, 1'b1, 32'h0000_6000, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'h1234_5000, 1'b0, 8'd8},  // R8 key1 pp2 write
    '{2'd0, 1'b0, 32'h0004_6000, 2'd1, 20'h0F0F0, 2'b01, 1'b1, 2'd0, 32'h0F0F_0000, 1'b0, 8'd7},  // R7 page mismatch
    '{2'd0, 1'b0, 32'h2000_6008, 2'd2, 20'h0,     2'b00, 1'b0, 2'd2, 32'h0,         1'b0, 8'd7},  // R7 vsid mismatch
    '{2'd0, 1'b1, 32'h0004_6008, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'h0F0F_0008, 1'b0, 8'd8},  // R8 key1 pp1 read
    '{2'd1, 1'b1, 32'h0004_600C, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8},  // R8 key1 pp1 write
    '{2'd1, 1'b0, 32'h0004_6000, 2'd0, 20'h0,     2'b00, 1'b0, 2'd0, 32'h0F0F_0000, 1'b0, 8'd9},  // R9 filled changed
    '{2'd2, 1'b0, 32'h1000_0000, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd4},  // R4 no-execute
    '{2'd2, 1'b0, 32'h0000_5000, 2'd1, 20'h55555, 2'b00, 1'b0, 2'd0, 32'h5555_5000, 1'b0, 8'd12}, // R12 own cache
    '{2'd2, 1'b1, 32'h0000_5004, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8},  // R8 key1 pp0 fetch
    '{2'd0, 1'b1, 32'h1000_7000, 2'd1, 20'h77777, 2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8},  // R8 fill then deny
    '{2'd1, 1'b0, 32'h1000_7000, 2'd0, 20'h0,     2'b00, 1'b0, 2'd1, 32'h0,         1'b0, 8'd8}   // R8 Ks1 pp0 write
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd20000, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) segModel[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, 1, "reqReady", {31'h0, reqReady}, 32'h1);
    check(rspValid == 1'b0, 1, "rspValid", {31'h0, rspValid}, 32'h0);
    check(walkReq == 1'b0, 1, "walkReq", {31'h0, walkReq}, 32'h0);
    check(chgReq == 1'b0 && cfgErr == 1'b0, 1, "chgReq/cfgErr", {30'h0, chgReq, cfgErr}, 32'h0);

    segWrite(4'd0, 32'h2000_0111);
    check(cfgErr == 1'b0, 3, "cfgErr on valid write", {31'h0, cfgErr}, 32'h0);
    segWrite(4'd1, 32'h7000_0222);
    segWrite(4'd2, 32'h0000_0333);

    foreach (VECS[i]) begin
      access(VECS[i].kind, VECS[i].prob, VECS[i].addr, VECS[i].walk, VECS[i].rpn,
             VECS[i].pp, VECS[i].chg, VECS[i].flt, VECS[i].ra, VECS[i].chgReq,
             int'(VECS[i].req));
    end

    // R3 rejected segment value
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 4'd3; segWrData = 32'h8000_0999;
    @(negedge clk);
    segWrEn = 1'b0;
    check(cfgErr == 1'b1, 3, "cfgErr raised", {31'h0, cfgErr}, 32'h1);
    @(negedge clk);
    check(cfgErr == 1'b0, 3, "cfgErr one cycle", {31'h0, cfgErr}, 32'h0);
    access(2'd0, 1'b0, 32'h3000_1000, 2'd2, 20'h0, 2'b00, 1'b0, 2'd2, 32'h0, 1'b0, 3);

    // R10 invalidate one slot in both caches
    @(negedge clk);
    invOne = 1'b1; invAddr = 32'hFFF0_5ABC;
    @(negedge clk);
    invOne = 1'b0;
    access(2'd0, 1'b0, 32'h0000_5000, 2'd1, 20'hABCDE, 2'b11, 1'b0, 2'd0, 32'hABCD_E000, 1'b0, 10);
    access(2'd2, 1'b0, 32'h0000_5008, 2'd1, 20'h55555, 2'b00, 1'b0, 2'd0, 32'h5555_5008, 1'b0, 10);
    access(2'd0, 1'b0, 32'h0004_6004, 2'd0, 20'h0, 2'b00, 1'b0, 2'd0, 32'h0F0F_0004, 1'b0, 10);

    // R11 invalidate all
    @(negedge clk);
    invAll = 1'b1;
    @(negedge clk);
    invAll = 1'b0;
    access(2'd0, 1'b0, 32'h0004_6000, 2'd2, 20'h0, 2'b00, 1'b0, 2'd2, 32'h0, 1'b0, 11);
    access(2'd2, 1'b0, 32'h0000_5000, 2'd2, 20'h0, 2'b00, 1'b0, 2'd2, 32'h0, 1'b0, 11);
    access(2'd0, 1'b0, 32'h0000_5000, 2'd2, 20'h0, 2'b00, 1'b0, 2'd2, 32'h0, 1'b0, 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule